// File: doc/BRIEF.md
# PHY Management Register Sequencer

This block sits between a host's byte-wide register port and the two-wire management bus of an Ethernet PHY. The host chooses a PHY register number, then sets a command bit. The block generates the serial management frame on its own divided clock and raises a busy flag for the length of the frame. At the end of a read it places the 16-bit result in two byte-wide result registers. The host polls busy until it drops, and afterwards clears the command bit itself.

A second command bit selects continuous polling. While it is set, the block reads the chosen PHY register again and again. Before each read it raises a "data not yet valid" flag, and it lowers that flag when the read completes, so the host can pick up fresh results without issuing commands. Management writes are launched by writing the upper byte of a 16-bit write-data pair.

Top module: `mii_mgmt_seq`

## Requirements
- R1: After reset, and whenever no frame is in progress, `mdc` and `mdio_oe` are low. After reset the status register reads 0x04, and the command and result registers read 0x00.
- R2: The host register map is as follows. Address 0 is command: bit0 requests a read, bit1 requests continuous polling. Address 1 holds the 5-bit PHY register number. Address 2 is the write-data low byte and address 3 the write-data high byte. Address 4 is status: bit0 busy, bit1 polling on, bit2 data not valid. Address 5 is the result low byte and address 6 the result high byte. Address 7 reads 0. Every writable register reads back the value last written.
- R3: When command bit0 goes from 0 to 1 while the block is idle, a read starts. Busy is seen in the very next cycle and stays high for exactly (PRE_LEN+32)·2·MDC_HALF clock cycles. Writing bit0 as 1 when it is already 1 starts nothing, and bit0 keeps its value until the host writes it again.
- R4: A frame is made of PRE_LEN ones, then start 0,1, then the opcode (1,0 for a read, 0,1 for a write), then the 5-bit PHY address, then the 5-bit register number, then two turnaround bits, then 16 data bits, each field MSB first. One bit lasts one `mdc` period: `mdc` is low for MDC_HALF cycles and then high for MDC_HALF cycles. The bit changes while `mdc` is low.
- R5: On a read, `mdio_oe` is low for the two turnaround bits and all 16 data bits. The data bits are sampled on the rising edges of `mdc`. When busy drops, the result appears at addresses 5 and 6, high byte at 6.
- R6: Writing address 3 while idle starts a write frame. Its turnaround bits are 1,0 and its data is {value written to address 3, content of address 2}.
- R7: A read request, a poll or a write launch that arrives while busy is dropped: it causes no second frame.
- R8: While command bit1 is set, a new read of the selected register starts one idle cycle after each read ends. Status bit1 mirrors command bit1, and the result registers are rewritten at the end of every read.
- R9: The not-valid bit is set in the cycle in which a read starts and is cleared when that read completes. Write frames leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data (combinational on host_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven to the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data from the PHY |

## Verification
The hardest condition to reach is a request arriving exactly when the engine is already busy or is just finishing a frame. Two cases matter most: a read re-armed by clearing and setting bit0 in the middle of a frame, and a poll that must restart one cycle after completion. The bench drives clear-and-set of the read bit and a write launch in the middle of a frame. It leaves polling on across several back-to-back reads while a modelled PHY returns a different value on each read. A behavioural model predicts the busy, polling and not-valid bits on every cycle, so a missed or extra frame shows up as a status mismatch.

// File: rtl/mii_seq_pkg.sv
package mii_seq_pkg;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_PHYREG = 3'd1,
    RA_WLO    = 3'd2,
    RA_WHI    = 3'd3,
    RA_STAT   = 3'd4,
    RA_RLO    = 3'd5,
    RA_RHI    = 3'd6
  } reg_sel_e;

  // bits in one frame: preamble plus 32 fixed-format bits
  function automatic int unsigned frame_bits(int unsigned pre);
    return pre + 32;
  endfunction

  // cycles a whole frame occupies
  function automatic int unsigned frame_cycles(int unsigned pre, int unsigned half);
    return frame_bits(pre) * 2 * half;
  endfunction

  // value to drive for bit position idx of a frame
  function automatic logic frame_bit(int unsigned idx, int unsigned pre, logic rd,
                                     logic [4:0] phy, logic [4:0] rg, logic [15:0] wd);
    logic [31:0] body;
    int unsigned j;
    if (idx < pre) return 1'b1;
    j = idx - pre;
    body = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wd};
    return body[5'(31 - j)];
  endfunction

  // read frames release the line from the turnaround on
  function automatic logic frame_released(int unsigned idx, int unsigned pre, logic rd);
    return rd && (idx >= pre + 14);
  endfunction

endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
  parameter int MDC_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [CW-1:0] LIM = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == LIM);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mii_frame_engine.sv
module mii_frame_engine #(
  parameter int         PRE_LEN  = 32,
  parameter int         MDC_HALF = 2,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        go_rd,
  input  logic [4:0]  go_reg,
  input  logic [15:0] go_wd,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        rd_op,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  import mii_seq_pkg::*;

  localparam int TOTAL = int'(frame_bits(PRE_LEN));
  localparam int IW    = $clog2(TOTAL);
  localparam logic [IW-1:0] LAST   = IW'(TOTAL - 1);
  localparam logic [IW-1:0] DFIRST = IW'(PRE_LEN + 16);

  logic [IW-1:0] idx;
  logic [4:0]    reg_q;
  logic [15:0]   wd_q;
  logic [15:0]   shreg;
  logic          rise, fall;

  mii_mdc_gen #(.MDC_HALF(MDC_HALF)) u_mdc (
    .clk (clk),
    .rst_n(rst_n),
    .run (busy),
    .mdc (mdc),
    .rise(rise),
    .fall(fall)
  );

  assign done    = fall && (idx == LAST);
  assign rd_data = shreg;
  assign mdio_o  = busy && frame_bit(32'(idx), PRE_LEN, rd_op, PHY_ADDR, reg_q, wd_q);
  assign mdio_oe = busy && !frame_released(32'(idx), PRE_LEN, rd_op);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      rd_op <= 1'b0;
      reg_q <= '0;
      wd_q  <= '0;
      idx   <= '0;
      shreg <= '0;
    end else if (go && !busy) begin
      busy  <= 1'b1;
      rd_op <= go_rd;
      reg_q <= go_reg;
      wd_q  <= go_wd;
      idx   <= '0;
    end else if (busy) begin
      if (rise && rd_op && idx >= DFIRST)
        shreg <= {shreg[14:0], mdio_i};
      if (fall) begin
        if (idx == LAST) busy <= 1'b0;
        else             idx  <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mii_mgmt_seq.sv
module mii_mgmt_seq #(
  parameter int         PRE_LEN  = 32,
  parameter int         MDC_HALF = 2,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       mdc,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic       mdio_i
);
  import mii_seq_pkg::*;

  logic        cmd_rd, cmd_scan, data_nv;
  logic [4:0]  regsel;
  logic [7:0]  wd_lo, wd_hi, res_lo, res_hi;
  logic        rd_go, wr_go, eng_go, eng_go_rd;
  logic        eng_busy, eng_done, eng_rd;
  logic [15:0] eng_data;

  // launch requests; the engine ignores them while busy
  assign rd_go     = host_wr && (host_addr == RA_CTRL) && host_wdata[0] && !cmd_rd;
  assign wr_go     = host_wr && (host_addr == RA_WHI);
  assign eng_go_rd = rd_go || cmd_scan;
  assign eng_go    = eng_go_rd || wr_go;

  mii_frame_engine #(.PRE_LEN(PRE_LEN), .MDC_HALF(MDC_HALF), .PHY_ADDR(PHY_ADDR)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (eng_go),
    .go_rd  (eng_go_rd),
    .go_reg (regsel),
    .go_wd  ({host_wdata, wd_lo}),
    .mdio_i (mdio_i),
    .busy   (eng_busy),
    .done   (eng_done),
    .rd_op  (eng_rd),
    .rd_data(eng_data),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_rd   <= 1'b0;
      cmd_scan <= 1'b0;
      regsel   <= '0;
      wd_lo    <= '0;
      wd_hi    <= '0;
      res_lo   <= '0;
      res_hi   <= '0;
      data_nv  <= 1'b1;
    end else begin
      if (host_wr) begin
        case (host_addr)
          RA_CTRL:   {cmd_scan, cmd_rd} <= host_wdata[1:0];
          RA_PHYREG: regsel <= host_wdata[4:0];
          RA_WLO:    wd_lo  <= host_wdata;
          RA_WHI:    wd_hi  <= host_wdata;
          default: ;
        endcase
      end
      if (eng_go && !eng_busy && eng_go_rd)
        data_nv <= 1'b1;
      else if (eng_done && eng_rd) begin
        data_nv <= 1'b0;
        {res_hi, res_lo} <= eng_data;
      end
    end
  end

  always_comb begin
    case (host_addr)
      RA_CTRL:   host_rdata = {6'b0, cmd_scan, cmd_rd};
      RA_PHYREG: host_rdata = {3'b0, regsel};
      RA_WLO:    host_rdata = wd_lo;
      RA_WHI:    host_rdata = wd_hi;
      RA_STAT:   host_rdata = {5'b0, data_nv, cmd_scan, eng_busy};
      RA_RLO:    host_rdata = res_lo;
      RA_RHI:    host_rdata = res_hi;
      default:   host_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/mii_seq_checks.sv
module mii_seq_checks (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic rd_op,
  input logic mdc,
  input logic mdio_oe,
  input logic scan_on,
  input logic nv
);
  // R3: busy only drops at the frame's last falling mdc step
  a_r3_busy_drop_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  // R3: completion always ends the busy period
  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R1: management clock parked low while idle
  a_r1_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R6: write frames never release the line
  a_r6_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_op) |-> mdio_oe);

  // R9: not-valid flag raised when a read begins
  a_r9_nv_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && rd_op) |-> nv);

  // R9: not-valid flag cleared by read completion
  a_r9_nv_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_op) |=> !nv);

  // R8: polling restarts after one idle cycle
  a_r8_poll_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done && scan_on ##1 scan_on) |=> busy);
endmodule

bind mii_mgmt_seq mii_seq_checks u_checks (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (eng_busy),
  .done   (eng_done),
  .rd_op  (eng_rd),
  .mdc    (mdc),
  .mdio_oe(mdio_oe),
  .scan_on(cmd_scan),
  .nv     (data_nv)
);

// File: tb/mii_mgmt_seq_bench.sv
`timescale 1ns/1ps
module mii_mgmt_seq_bench;
  localparam int PRE  = 32;
  localparam int HALF = 2;
  localparam logic [4:0] PHY = 5'd1;
  localparam int TOT  = PRE + 32;
  localparam int NCYC = TOT * 2 * HALF;

  logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0, mdio_i = 1'b1;
  logic [2:0] host_addr = 3'd4;
  logic [7:0] host_wdata = 8'h00;
  wire  [7:0] host_rdata;
  wire  mdc, mdio_o, mdio_oe;

  always #2 clk = ~clk;

  mii_mgmt_seq #(.PRE_LEN(PRE), .MDC_HALF(HALF), .PHY_ADDR(PHY)) u_mii_mgmt_seq (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference state
  int         m_rem = 0, m_salt = 0;
  bit         m_rd = 0, m_cmd0 = 0, m_scan = 0, m_nv = 1;
  logic [4:0] m_regsel = 0, m_treg = 0;
  logic [7:0] m_wdlo = 0, m_wdhi = 0, m_rdlo = 0, m_rdhi = 0;
  logic [15:0] m_twd = 0, m_val = 0;
  int cap[TOT];
  int phy_k = 0;

  function automatic logic [15:0] phy_val(logic [4:0] r, int s);
    return {3'b101, r, 3'b010, ~r} ^ 16'(s * 257);
  endfunction

  // expected line value per bit: 0/1 driven, 2 released
  function automatic int exp_frame(int k, bit rd, logic [4:0] r, logic [15:0] wd);
    int j;
    if (k < PRE) return 1;
    j = k - PRE;
    if (j < 2)  return j;
    if (j < 4)  return rd ? int'(j == 2) : int'(j == 3);
    if (j < 9)  return int'(PHY[8 - j]);
    if (j < 14) return int'(r[13 - j]);
    if (rd)     return 2;
    if (j < 16) return int'(j == 14);
    return int'(wd[31 - j]);
  endfunction

  function automatic logic [7:0] exp_rdata(logic [2:0] a);
    case (a)
      3'd0: return {6'b0, m_scan, m_cmd0};
      3'd1: return {3'b0, m_regsel};
      3'd2: return m_wdlo;
      3'd3: return m_wdhi;
      3'd4: return {5'b0, m_nv, m_scan, m_rem > 0};
      3'd5: return m_rdlo;
      3'd6: return m_rdhi;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, advanced on every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem = 0; m_cmd0 = 0; m_scan = 0; m_nv = 1; m_regsel = 0;
      m_wdlo = 0; m_wdhi = 0; m_rdlo = 0; m_rdhi = 0; m_salt = 0;
    end else begin
      if (m_rem > 0) begin
        m_rem--;
        if (m_rem == 0) begin
          for (int k = 0; k < TOT; k++)
            chk(m_rd ? "R4 R5 read frame bit" : "R4 R6 write frame bit",
                cap[k], exp_frame(k, m_rd, m_treg, m_twd));
          chk("R4 bit count", phy_k, TOT);
          if (m_rd) begin
            {m_rdhi, m_rdlo} = m_val;
            m_nv = 0;
          end
        end
      end else begin
        bit rgo, wgo;
        rgo = host_wr && host_addr == 3'd0 && host_wdata[0] && !m_cmd0;
        wgo = host_wr && host_addr == 3'd3;
        if (rgo || m_scan || wgo) begin
          m_rem = NCYC;
          m_rd  = rgo || m_scan;
          m_treg = m_regsel;
          m_twd = {host_wdata, m_wdlo};
          m_val = phy_val(m_regsel, m_salt);
          m_salt++;
          phy_k = 0;
          for (int k = 0; k < TOT; k++) cap[k] = 9;
          if (m_rd) m_nv = 1;
        end
      end
      if (host_wr) begin
        case (host_addr)
          3'd0: begin m_cmd0 = host_wdata[0]; m_scan = host_wdata[1]; end
          3'd1: m_regsel = host_wdata[4:0];
          3'd2: m_wdlo = host_wdata;
          3'd3: m_wdhi = host_wdata;
          default: ;
        endcase
      end
    end
  end

  // PHY model: capture on rising mdc, present read data after falling mdc
  always @(posedge mdc) begin
    if (phy_k < TOT) cap[phy_k] = mdio_oe ? int'(mdio_o) : 2;
    phy_k++;
  end

  always @(negedge mdc) begin
    int j;
    j = phy_k - PRE - 16;
    mdio_i = (j >= 0 && j < 16) ? m_val[15 - j] : 1'b1;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk(host_addr == 3'd4 ? "R3 R8 R9 status" : "R2 register readback",
          host_rdata, exp_rdata(host_addr));
      if (m_rem == 0) begin
        chk("R1 idle mdc", mdc, 0);
        chk("R1 idle oe", mdio_oe, 0);
      end
    end
  end

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0; host_addr = 3'd4;
  endtask

  task automatic peek(logic [2:0] a, int exp, string req);
    @(negedge clk); host_addr = a;
    #1 chk(req, host_rdata, exp);
    @(negedge clk); host_addr = 3'd4;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (m_rem > 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset status", host_rdata, 8'h04);
    peek(3'd0, 8'h00, "R1 reset command");
    peek(3'd5, 8'h00, "R1 reset result low");
    peek(3'd6, 8'h00, "R1 reset result high");

    // R2 plus R3/R5: single read of register 5
    wr_reg(3'd1, 8'h05);
    peek(3'd1, 8'h05, "R2 register number readback");
    wr_reg(3'd0, 8'h01);
    wait_idle();
    v = phy_val(5'd5, 0);
    peek(3'd5, v[7:0], "R5 result low byte");
    peek(3'd6, v[15:8], "R5 result high byte");
    peek(3'd0, 8'h01, "R3 read bit held");

    // R3: setting an already set read bit starts nothing
    wr_reg(3'd0, 8'h01);
    repeat (10) @(negedge clk);
    #1 chk("R3 no relaunch", host_rdata, 8'h00);
    wr_reg(3'd0, 8'h00);

    // R6 and R9: write frame, not-valid untouched
    wr_reg(3'd2, 8'h3C);
    wr_reg(3'd3, 8'h9E);
    #1 chk("R9 write leaves flag", host_rdata, 8'h01);
    wait_idle();
    peek(3'd3, 8'h9E, "R2 write high readback");

    // R7: requests during a read are dropped
    wr_reg(3'd1, 8'h0A);
    wr_reg(3'd0, 8'h01);
    repeat (20) @(negedge clk);
    wr_reg(3'd3, 8'h11);
    wr_reg(3'd0, 8'h00);
    wr_reg(3'd0, 8'h01);
    wait_idle();
    repeat (5) @(negedge clk);
    #1 chk("R7 no extra frame", host_rdata, 8'h00);
    v = phy_val(5'd10, 2);
    peek(3'd5, v[7:0], "R7 result low");
    peek(3'd6, v[15:8], "R7 result high");
    wr_reg(3'd0, 8'h00);

    // R8: polling across several reads
    wr_reg(3'd1, 8'h1F);
    wr_reg(3'd0, 8'h02);
    repeat (3 * NCYC + 10) @(negedge clk);
    wr_reg(3'd0, 8'h00);
    wait_idle();
    #1 chk("R8 polling stopped", host_rdata, 8'h00);
    v = phy_val(5'd31, m_salt - 1);
    peek(3'd5, v[7:0], "R8 last poll low");
    peek(3'd6, v[15:8], "R8 last poll high");
    chk("R8 poll count", m_salt, 7);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule